// File: doc/BRIEF.md
# Indexed Real-Time Clock Register File

This block is a calendar clock that software reaches through two byte ports: an index port and a data port. A byte written to the index port chooses which clock register a later data-port read returns. The block keeps second, minute, hour, weekday, day-of-month, month and year counters in binary. A one-second strobe advances them, and day carries follow the month lengths, including February in leap years. The starting time comes from parameters and is loaded at reset.

The control registers hold fixed values. The first control register also carries an update-in-progress bit, which flips on every read of that register. The data port is read-only. A write to it, or a read of a register that is not mapped, raises a one-cycle error pulse.

A separate divider counts cycles of a tick-enable input and emits a one-cycle periodic interrupt. With a 32768 Hz tick-enable and the default divide of 32, this interrupt runs at 1024 Hz. The divider runs without a break from the end of reset.

Top module: `rtc_indexed_clock`

## Requirements
- R1: A write with `port_sel`=0 stores `wr_data` as the register index. A read with `port_sel`=0 returns the stored index, which is 0 after reset. Every read puts its byte on `rd_data` with `rd_valid` high in the cycle after `rd_en`. A read issued in the same cycle as an index write uses the old index.
- R2: Data-port reads return the time fields in binary, by index: 0 gives seconds, 2 gives minutes, 4 gives hours (0 to 23), 6 gives weekday (0 to 6) and 7 gives day of month.
- R3: Index 10 reads as the update-in-progress bit in bit 7 with 0x26 in bits 6:0. The bit is 1 after reset and inverts after each read of index 10.
- R4: Index 11 always reads 0x46. Index 12 always reads 0x00.
- R5: Index 8 returns the month counted from 1. Index 9 returns the calendar year minus `YEAR_BASE`, modulo 256.
- R6: Each cycle with `sec_tick` high advances the seconds. Seconds carry into minutes at 60, minutes into hours at 60, and hours into the day at 24. The weekday steps on each day carry and wraps from 6 to 0.
- R7: A day carry past the last day of the month sets the day to 1 and advances the month. February has 29 days when the year is divisible by 4 and either not by 100 or by 400. December wraps to month 1 of the next year.
- R8: A write with `port_sel`=1 raises `err` for one cycle in the next cycle and changes no clock state.
- R9: A data-port read of index 13, or of any index not listed in R2 to R5, returns 0x00 with `rd_valid` and `err` both high in the next cycle.
- R10: `pi_irq` is a one-cycle pulse in the cycle after every `PI_DIV`-th cycle in which `tick_en` is high, counted from reset.
- R11: During and right after reset, `rd_valid`, `err`, `rd_data` and `pi_irq` are 0, and the time equals the `INIT_*` parameters.
- R12: A read issued in the same cycle as `sec_tick` returns the value from before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-second advance strobe |
| tick_en | input | 1 | Tick-enable input to the periodic interrupt divider |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid while `rd_valid` is high |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_en` |
| err | output | 1 | Unsupported access pulse |
| pi_irq | output | 1 | Periodic interrupt pulse |

## Verification
Two functions can fall in the same cycle: a software read of the seconds register and the one-second strobe that changes that register. The bench raises `rd_en` and `sec_tick` in the same cycle, with the index pointing at seconds. It expects the pre-tick seconds value on `rd_data`, and it expects the following read to show the incremented value. The periodic divider keeps running through every bus access, and a separate monitor counts the `tick_en` cycles between consecutive `pi_irq` pulses.

// File: rtl/rtc_idx_pkg.sv
// Package: shared constants, the time record and the calendar helpers.
// Assumes years fit in YEAR_W bits and that months are numbered 1..12.
package rtc_idx_pkg;

    localparam int YEAR_W = 12;
    localparam int SEC_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DOW_W  = 3;
    localparam int DOM_W  = 5;
    localparam int MON_W  = 4;

    // Register indexes. Software decodes these, so the positions are fixed.
    localparam logic [7:0] IX_SEC  = 8'd0;
    localparam logic [7:0] IX_MIN  = 8'd2;
    localparam logic [7:0] IX_HOUR = 8'd4;
    localparam logic [7:0] IX_DOW  = 8'd6;
    localparam logic [7:0] IX_DOM  = 8'd7;
    localparam logic [7:0] IX_MON  = 8'd8;
    localparam logic [7:0] IX_YEAR = 8'd9;
    localparam logic [7:0] IX_CTLA = 8'd10;
    localparam logic [7:0] IX_CTLB = 8'd11;
    localparam logic [7:0] IX_CTLC = 8'd12;

    localparam logic [6:0] CTLA_LOW = 7'h26;
    localparam logic [7:0] CTLB_VAL = 8'h46;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [DOM_W-1:0]  dom;
        logic [DOW_W-1:0]  dow;
        logic [HOUR_W-1:0] hour;
        logic [SEC_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } rtc_time_t;

    // Gregorian leap-year rule.
    function automatic logic is_leap(input logic [YEAR_W-1:0] y);
        return (y[1:0] == 2'b00) &&
               (((y % YEAR_W'(100)) != '0) || ((y % YEAR_W'(400)) == '0));
    endfunction

    // Last day of a month.
    function automatic logic [DOM_W-1:0] month_days(input logic [MON_W-1:0] m,
                                                    input logic leap);
        case (m)
            MON_W'(2):                       return leap ? DOM_W'(29) : DOM_W'(28);
            MON_W'(4), MON_W'(6),
            MON_W'(9), MON_W'(11):           return DOM_W'(30);
            default:                         return DOM_W'(31);
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_core.sv
// Time core: binary calendar counters advanced by a one-second strobe.
// Assumes the INIT_* parameters describe a valid date and time.
module rtc_time_core
    import rtc_idx_pkg::*;
#(
    parameter int INIT_SEC   = 0,
    parameter int INIT_MIN   = 0,
    parameter int INIT_HOUR  = 0,
    parameter int INIT_DOW   = 0,
    parameter int INIT_DOM   = 1,
    parameter int INIT_MON   = 1,
    parameter int INIT_YEAR  = 2006
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_tick,
    output rtc_time_t now
);

    localparam rtc_time_t INIT_T = '{
        year: YEAR_W'(INIT_YEAR), mon: MON_W'(INIT_MON), dom: DOM_W'(INIT_DOM),
        dow: DOW_W'(INIT_DOW), hour: HOUR_W'(INIT_HOUR), min: SEC_W'(INIT_MIN),
        sec: SEC_W'(INIT_SEC)
    };

    rtc_time_t          t_q;
    logic [DOM_W-1:0]   last_day;

    // Last day of the current month, taking the leap rule into account.
    always_comb last_day = month_days(t_q.mon, is_leap(t_q.year));

    // Carry chain: sec -> min -> hour -> day/weekday -> month -> year.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= INIT_T;
        end else if (sec_tick) begin
            if (t_q.sec != SEC_W'(59)) begin
                t_q.sec <= t_q.sec + SEC_W'(1);
            end else begin
                t_q.sec <= '0;
                if (t_q.min != SEC_W'(59)) begin
                    t_q.min <= t_q.min + SEC_W'(1);
                end else begin
                    t_q.min <= '0;
                    if (t_q.hour != HOUR_W'(23)) begin
                        t_q.hour <= t_q.hour + HOUR_W'(1);
                    end else begin
                        t_q.hour <= '0;
                        t_q.dow  <= (t_q.dow == DOW_W'(6)) ? '0 : t_q.dow + DOW_W'(1);
                        if (t_q.dom != last_day) begin
                            t_q.dom <= t_q.dom + DOM_W'(1);
                        end else begin
                            t_q.dom <= DOM_W'(1);
                            if (t_q.mon != MON_W'(12)) begin
                                t_q.mon <= t_q.mon + MON_W'(1);
                            end else begin
                                t_q.mon  <= MON_W'(1);
                                t_q.year <= t_q.year + YEAR_W'(1);
                            end
                        end
                    end
                end
            end
        end
    end

    assign now = t_q;

endmodule

// File: rtl/rtc_pi_gen.sv
// Periodic interrupt generator: divides a tick-enable input by PI_DIV.
// Assumes PI_DIV >= 2, so that pulses are always one cycle wide.
module rtc_pi_gen #(
    parameter int PI_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic pulse
);

    localparam int CW = (PI_DIV > 1) ? $clog2(PI_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(PI_DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count enabled ticks and pulse once per PI_DIV of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick_en) begin
                if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    pulse <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rtc_port_if.sv
// Port interface: index latch, read multiplexer, update-in-progress
// toggle and error detection. Assumes at most one read and one write per cycle.
module rtc_port_if
    import rtc_idx_pkg::*;
#(
    parameter int YEAR_BASE = 1952
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic       port_sel,
    input  logic [7:0] wr_data,
    input  rtc_time_t  now,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       err,
    output logic [7:0] idx
);

    logic [7:0]        idx_q;
    logic              uip_q;
    logic [7:0]        mux_byte;
    logic              mux_bad;
    logic [YEAR_W-1:0] year_ofs;

    // Year as reported: the calendar year minus the base.
    always_comb year_ofs = now.year - YEAR_W'(YEAR_BASE);

    // Select the data-port byte for the current index, and flag unmapped indexes.
    always_comb begin
        mux_bad  = 1'b0;
        mux_byte = 8'h00;
        case (idx_q)
            IX_SEC:  mux_byte = 8'(now.sec);
            IX_MIN:  mux_byte = 8'(now.min);
            IX_HOUR: mux_byte = 8'(now.hour);
            IX_DOW:  mux_byte = 8'(now.dow);
            IX_DOM:  mux_byte = 8'(now.dom);
            IX_MON:  mux_byte = 8'(now.mon);
            IX_YEAR: mux_byte = year_ofs[7:0];
            IX_CTLA: mux_byte = {uip_q, CTLA_LOW};
            IX_CTLB: mux_byte = CTLB_VAL;
            IX_CTLC: mux_byte = 8'h00;
            default: mux_bad  = 1'b1;
        endcase
    end

    // Register the read results, the error pulse, the index and the toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= 8'h00;
            uip_q    <= 1'b1;
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
            err      <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            err      <= (wr_en && port_sel) || (rd_en && port_sel && mux_bad);
            if (rd_en)
                rd_data <= port_sel ? mux_byte : idx_q;
            if (wr_en && !port_sel)
                idx_q <= wr_data;
            if (rd_en && port_sel && (idx_q == IX_CTLA))
                uip_q <= ~uip_q;
        end
    end

    assign idx = idx_q;

endmodule

// File: rtl/rtc_indexed_clock.sv
// Top: indexed real-time clock. It ties together the calendar core, the
// periodic interrupt divider and the index/data port interface.
// Assumes sec_tick and tick_en are synchronous to clk.
module rtc_indexed_clock
    import rtc_idx_pkg::*;
#(
    parameter int PI_DIV     = 32,
    parameter int YEAR_BASE  = 1952,
    parameter int INIT_SEC   = 0,
    parameter int INIT_MIN   = 0,
    parameter int INIT_HOUR  = 0,
    parameter int INIT_DOW   = 0,
    parameter int INIT_DOM   = 1,
    parameter int INIT_MON   = 1,
    parameter int INIT_YEAR  = 2006
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       tick_en,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic       port_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       err,
    output logic       pi_irq
);

    rtc_time_t  now_q;
    logic [7:0] idx_q;

    rtc_time_core #(
        .INIT_SEC(INIT_SEC), .INIT_MIN(INIT_MIN), .INIT_HOUR(INIT_HOUR),
        .INIT_DOW(INIT_DOW), .INIT_DOM(INIT_DOM), .INIT_MON(INIT_MON),
        .INIT_YEAR(INIT_YEAR)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .now(now_q)
    );

    rtc_pi_gen #(.PI_DIV(PI_DIV)) u_pi (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pulse(pi_irq)
    );

    rtc_port_if #(.YEAR_BASE(YEAR_BASE)) u_port (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .port_sel(port_sel), .wr_data(wr_data), .now(now_q),
        .rd_data(rd_data), .rd_valid(rd_valid), .err(err), .idx(idx_q)
    );

endmodule

// File: rtl/rtc_indexed_clock_chk.sv
// Checker: temporal properties of the indexed clock, bound to the top module.
module rtc_indexed_clock_chk
    import rtc_idx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic              port_sel,
    input logic [7:0]        idx,
    input logic [7:0]        rd_data,
    input logic              rd_valid,
    input logic              err,
    input logic              pi_irq,
    input logic [SEC_W-1:0]  sec,
    input logic [DOM_W-1:0]  dom
);

    AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R1
    AST_CTLA_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel && idx == IX_CTLA) |=> (rd_data[6:0] == CTLA_LOW)); // R3
    AST_CTLB_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel && idx == IX_CTLB) |=> (rd_data == CTLB_VAL && !err)); // R4
    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sec < SEC_W'(60)); // R6
    AST_DOM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dom >= DOM_W'(1)) && (dom <= DOM_W'(31))); // R7
    AST_DATA_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_sel) |=> err); // R8
    AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> !err); // R9
    AST_PI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pi_irq |=> !pi_irq); // R10

endmodule

bind rtc_indexed_clock rtc_indexed_clock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .port_sel(port_sel), .idx(idx_q), .rd_data(rd_data),
    .rd_valid(rd_valid), .err(err), .pi_irq(pi_irq),
    .sec(now_q.sec), .dom(now_q.dom)
);

// File: tb/sim_rtc_indexed_clock.sv
// Scoreboard bench: driver tasks queue expected bus results; a monitor pops them.
module sim_rtc_indexed_clock;

    localparam int PI_DIV = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       tick_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       port_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       err;
    logic       pi_irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ticks_seen = 0;
    int pulses = 0;
    bit done = 1'b0;

    typedef struct packed { logic v; logic [7:0] d; logic e; } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    rtc_indexed_clock #(
        .PI_DIV(PI_DIV), .YEAR_BASE(1952),
        .INIT_SEC(58), .INIT_MIN(59), .INIT_HOUR(23), .INIT_DOW(5),
        .INIT_DOM(28), .INIT_MON(2), .INIT_YEAR(2008)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .tick_en(tick_en),
        .rd_en(rd_en), .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .err(err), .pi_irq(pi_irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: compare every read or error result against the queue.
    always @(negedge clk) begin
        if (rst_n && (rd_valid || err)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected result", {rd_valid, err, rd_data}, 0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_valid == e.v && err == e.e && (!e.v || rd_data == e.d),
                      t, {rd_valid, err, rd_data}, {e.v, e.e, e.d});
            end
        end
    end

    // Count enabled ticks as the divider sees them.
    always @(posedge clk) if (rst_n && tick_en) ticks_seen++;

    // R10: each pulse follows exactly PI_DIV enabled ticks.
    always @(negedge clk) begin
        if (rst_n && pi_irq && !done) begin
            check(ticks_seen == PI_DIV, "R10 pi interval", ticks_seen, PI_DIV);
            ticks_seen = 0;
            pulses++;
        end
    end

    // Drive tick_en with a gapped pattern.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            tick_en = rst_n && (cyc % 5 != 0);
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d, input bit exp_err, input string tag);
        wr_en = 1'b1; port_sel = sel; wr_data = d;
        if (exp_err) begin
            exp_q.push_back('{v: 1'b0, d: 8'h00, e: 1'b1});
            tag_q.push_back(tag);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] expd, input bit exp_err,
                      input string tag);
        rd_en = 1'b1; port_sel = sel;
        exp_q.push_back('{v: 1'b1, d: expd, e: exp_err});
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] i, input logic [7:0] expd, input string tag);
        wr(1'b0, i, 1'b0, "");
        rd(1'b1, expd, 1'b0, tag);
    endtask

    task automatic tick(input int n);
        sec_tick = 1'b1;
        repeat (n) @(negedge clk);
        sec_tick = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check(rd_valid == 0 && err == 0 && rd_data == 0 && pi_irq == 0,
              "R11 reset outputs", {rd_valid, err, rd_data, pi_irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b0, 8'h00, 1'b0, "R1 reset index");
        rd_reg(8'd0, 8'd58, "R11 R2 init seconds");
        rd_reg(8'd2, 8'd59, "R2 minutes");
        rd_reg(8'd4, 8'd23, "R2 hours");
        rd_reg(8'd6, 8'd5,  "R2 weekday");
        rd_reg(8'd7, 8'd28, "R2 day of month");
        rd_reg(8'd8, 8'd2,  "R5 month one-based");
        rd_reg(8'd9, 8'd56, "R5 year offset");
        rd(1'b0, 8'd9, 1'b0, "R1 index readback");
        rd_reg(8'd10, 8'hA6, "R3 uip first read");
        rd(1'b1, 8'h26, 1'b0, "R3 uip toggled");
        rd(1'b1, 8'hA6, 1'b0, "R3 uip toggled back");
        rd_reg(8'd11, 8'h46, "R4 control B");
        rd_reg(8'd12, 8'h00, "R4 control C");
        wr(1'b0, 8'd13, 1'b0, "");
        rd(1'b1, 8'h00, 1'b1, "R9 register D");
        wr(1'b0, 8'd1, 1'b0, "");
        rd(1'b1, 8'h00, 1'b1, "R9 unmapped index 1");
        wr(1'b0, 8'h40, 1'b0, "");
        rd(1'b1, 8'h00, 1'b1, "R9 unmapped index 0x40");
        wr(1'b0, 8'd0, 1'b0, "");
        wr(1'b1, 8'h11, 1'b1, "R8 data port write");
        rd(1'b1, 8'd58, 1'b0, "R8 seconds unchanged");
        rd(1'b0, 8'd0, 1'b0, "R8 index unchanged");
        // R12: the read and the strobe share one cycle.
        rd_en = 1'b1; port_sel = 1'b1; sec_tick = 1'b1;
        exp_q.push_back('{v: 1'b1, d: 8'd58, e: 1'b0});
        tag_q.push_back("R12 read with tick sees old");
        @(negedge clk);
        rd_en = 1'b0; sec_tick = 1'b0;
        rd(1'b1, 8'd59, 1'b0, "R12 next read sees new");
        tick(1);
        rd_reg(8'd0, 8'd0,  "R6 seconds wrap");
        rd_reg(8'd2, 8'd0,  "R6 minutes wrap");
        rd_reg(8'd4, 8'd0,  "R6 hours wrap");
        rd_reg(8'd7, 8'd29, "R7 leap february 29");
        rd_reg(8'd8, 8'd2,  "R7 still february");
        rd_reg(8'd6, 8'd6,  "R6 weekday step");
        tick(86400);
        rd_reg(8'd7, 8'd1,  "R7 march 1");
        rd_reg(8'd8, 8'd3,  "R7 month advance");
        rd_reg(8'd6, 8'd0,  "R6 weekday wrap");
        rd_reg(8'd9, 8'd56, "R5 year kept");
        rd_reg(8'd0, 8'd0,  "R6 seconds after day");
        repeat (4) @(negedge clk);
        done = 1'b1;
        check(exp_q.size() == 0, "R1 all results seen", exp_q.size(), 0);
        check(pulses > 100, "R10 pulses produced", pulses, 101);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule